// File: doc/BRIEF.md
# Serial Receive Buffer with Trigger Level and Character Timeout

This block sits between a serial deserializer and the host-facing register logic of a serial controller. Each byte the deserializer assembles is written into a 16-entry circular byte store. The host drains the store one byte per read strobe. The block raises a trigger flag once the fill reaches a selectable threshold. It raises a timeout flag when data has been left sitting for four character times. Received break conditions are recorded in the same order as ordinary data.

A control write selects between FIFO operation and a single holding register, picks the threshold and can flush the store. Three line-setting inputs describe the frame. From them the block computes the character time in bit periods, and a one-bit-time tick advances the timeout count.

Top module: `serial_rx_buffer`

## Requirements
- R1: With FIFO operation on, bytes are read back in arrival order, up to 16 stored bytes. `level` reports the number held, from 0 to 16, and `data_ready` is high whenever `level` is non-zero.
- R2: Control bits [7:6] select the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. `trigger_hit` is high while `level` is at or above the selected value.
- R3: A byte that arrives while 16 bytes are stored is dropped, and the stored bytes stay unchanged. It also sets `overrun_flag`, which stays set until a receive flush.
- R4: Control bit 0 turns FIFO operation on. Bit 1 flushes the receive store, which empties it and clears `timeout_pend`, `overrun_flag` and `break_flag`. A write that changes bit 0 flushes as well. Bit 1 does not stick, so a later write that leaves bit 0 unchanged and has bit 1 clear keeps the stored data.
- R5: In FIFO mode, a timer counts `bit_tick` pulses. It restarts on every arriving byte and on every read. `timeout_pend` rises on the tick that completes four character times while data is stored. With the store empty the timer stays at zero.
- R6: Every read strobe clears `timeout_pend`. A read that leaves the store empty clears `data_ready` and `break_flag`.
- R7: A `rx_break` strobe stores a byte 0x00 and sets `break_flag` and `data_ready`.
- R8: The character time in bits is 1 + (5 + `lc_wlen`) + `lc_parity` + (1 + `lc_stop2`). It ranges from 7 to 12, so the timeout ranges from 28 to 48 ticks.
- R9: A read while the FIFO is empty returns 0x00 and moves no pointer, so the next byte written is the next byte read.
- R10: With FIFO operation off, one holding register is used and `level` is 0 or 1. A second byte that arrives before a read replaces the held byte and sets `overrun_flag`. A read clears `data_ready`, and `trigger_hit` follows `data_ready`.
- R11: After reset, FIFO operation is off and the buffer is empty. All flags are low and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break received strobe (stores 0x00) |
| rd_en | input | 1 | Receive buffer read strobe |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control value: [0] FIFO on, [1] receive flush, [7:6] threshold |
| lc_wlen | input | 2 | Data bits minus 5 |
| lc_parity | input | 1 | Parity bit present |
| lc_stop2 | input | 1 | Two stop bits |
| bit_tick | input | 1 | One pulse per bit time |
| rd_data | output | 8 | Byte presented for the current read |
| level | output | 5 | Number of stored bytes |
| data_ready | output | 1 | Data available |
| break_flag | output | 1 | Break recorded |
| overrun_flag | output | 1 | Byte lost to a full store |
| trigger_hit | output | 1 | Fill at or above threshold |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
The bench fills the store past 16 and then drains it. A design that overwrote on overrun would return 0xEE in place of the oldest byte, and one with a wrong wrap would reorder the bytes. It reads an empty store and then pushes again: a pointer that moved on an empty read would return a stale byte. It counts ticks to one short of the timeout and then exactly to it for two frame settings, so an off-by-one count or a wrong frame length shows up as early or missing `timeout_pend`. Break reads are checked with data left behind and with the store emptied, which catches a break flag cleared too early or left stuck.

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_break,
  input  logic          rd_en,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  input  logic [1:0]    lc_wlen,
  input  logic          lc_parity,
  input  logic          lc_stop2,
  input  logic          bit_tick,
  output logic [DW-1:0] rd_data,
  output logic [$clog2(DEPTH):0] level,
  output logic          data_ready,
  output logic          break_flag,
  output logic          overrun_flag,
  output logic          trigger_hit,
  output logic          timeout_pend
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = 6;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic [DW-1:0] hold;
  logic          hold_v;
  logic [1:0]    trig_sel;
  logic          fifo_on;
  logic [CW-1:0] tmo_cnt;

  logic          arrive, rx_clr, push, pop, drop, empty, full;
  logic [DW-1:0] in_byte;
  logic [AW:0]   trig_lvl;
  logic [3:0]    char_bits;
  logic [CW-1:0] tmo_limit;
  logic          tmo_fire, empties;

  assign arrive   = rx_valid | rx_break;
  assign in_byte  = rx_break ? '0 : rx_byte;
  assign empty    = (cnt == 0);
  assign full     = (cnt == (AW+1)'(DEPTH));
  assign rx_clr   = ctl_we & (ctl_wdata[1] | (ctl_wdata[0] ^ fifo_on));
  assign pop      = fifo_on & rd_en & ~empty;
  assign push     = fifo_on & arrive & ~full;
  assign drop     = fifo_on & arrive & full;
  assign empties  = fifo_on ? (rd_en & (cnt <= 1)) : rd_en;

  always_comb begin
    case (trig_sel)
      2'd0:    trig_lvl = (AW+1)'(1);
      2'd1:    trig_lvl = (AW+1)'(4);
      2'd2:    trig_lvl = (AW+1)'(8);
      default: trig_lvl = (AW+1)'(14);
    endcase
  end

  assign char_bits = 4'd7 + {2'b00, lc_wlen} + {3'b000, lc_parity} + {3'b000, lc_stop2};
  assign tmo_limit = {char_bits, 2'b00};
  assign tmo_fire  = fifo_on & bit_tick & ~empty & ~arrive & ~rd_en & (tmo_cnt == tmo_limit - 1'b1);

  assign rd_data      = fifo_on ? (empty ? '0 : mem[rptr]) : hold;
  assign level        = fifo_on ? cnt : {{AW{1'b0}}, hold_v};
  assign data_ready   = (level != 0);
  assign trigger_hit  = fifo_on ? (cnt >= trig_lvl) : hold_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_on  <= 1'b0;
      trig_sel <= 2'd0;
    end else if (ctl_we) begin
      fifo_on  <= ctl_wdata[0];
      trig_sel <= ctl_wdata[7:6];
    end
  end

  always_ff @(posedge clk) begin
    if (push && !rx_clr) mem[wptr] <= in_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (rx_clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold   <= '0;
      hold_v <= 1'b0;
    end else if (rx_clr) begin
      hold_v <= 1'b0;
    end else if (!fifo_on && arrive) begin
      hold   <= in_byte;
      hold_v <= 1'b1;
    end else if (!fifo_on && rd_en) begin
      hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      break_flag   <= 1'b0;
      overrun_flag <= 1'b0;
    end else if (rx_clr) begin
      break_flag   <= 1'b0;
      overrun_flag <= 1'b0;
    end else begin
      if (rx_break)      break_flag <= 1'b1;
      else if (empties)  break_flag <= 1'b0;
      if (drop || (!fifo_on && arrive && hold_v && !rd_en)) overrun_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_cnt      <= '0;
      timeout_pend <= 1'b0;
    end else begin
      if (rx_clr || !fifo_on || empty || arrive || rd_en) tmo_cnt <= '0;
      else if (bit_tick && tmo_cnt < tmo_limit) tmo_cnt <= tmo_cnt + 1'b1;
      if (rx_clr || rd_en) timeout_pend <= 1'b0;
      else if (tmo_fire)   timeout_pend <= 1'b1;
    end
  end
endmodule

module serial_rx_buffer_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_on,
  input logic          rx_valid,
  input logic          rx_break,
  input logic          rd_en,
  input logic          ctl_we,
  input logic [7:0]    ctl_wdata,
  input logic [DW-1:0] rd_data,
  input logic [$clog2(DEPTH):0] level,
  input logic          data_ready,
  input logic          break_flag,
  input logic          overrun_flag,
  input logic          timeout_pend
);
  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ($clog2(DEPTH)+1)'(DEPTH));
  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_on && level == ($clog2(DEPTH)+1)'(DEPTH) && rx_valid && !rd_en && !ctl_we
    |=> overrun_flag && level == ($clog2(DEPTH)+1)'(DEPTH));
  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_on && level == 0 && rd_en |-> rd_data == '0);
  // R6
  read_clears_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !timeout_pend);
  // R5
  tmo_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pend |-> data_ready);
  // R7
  break_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break && !ctl_we |=> break_flag && data_ready);
  // R4
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_wdata[1] |=> level == 0 && !timeout_pend && !overrun_flag);
endmodule

bind serial_rx_buffer serial_rx_buffer_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .rx_valid(rx_valid),
  .rx_break(rx_break), .rd_en(rd_en), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .rd_data(rd_data), .level(level), .data_ready(data_ready),
  .break_flag(break_flag), .overrun_flag(overrun_flag), .timeout_pend(timeout_pend)
);

// File: tb/serial_rx_buffer_bench.sv
module serial_rx_buffer_bench;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_break = 0, rd_en = 0, ctl_we = 0;
  logic [7:0] rx_byte = 0, ctl_wdata = 0;
  logic [1:0] lc_wlen = 2'd3;
  logic lc_parity = 0, lc_stop2 = 0, bit_tick = 0;
  logic [7:0] rd_data;
  logic [4:0] level;
  logic data_ready, break_flag, overrun_flag, trigger_hit, timeout_pend;

  int checks = 0, fails = 0;
  bit fifo_mode = 0, done = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  serial_rx_buffer u_serial_rx_buffer (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the expected byte for every read strobe
  initial forever begin
    @(negedge clk); #2;
    if (rd_en && rst_n) begin
      logic [7:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
      chk(rd_data == e, "R1/R9 read data", rd_data, e);
    end
  end

  task automatic push(input logic [7:0] b, input bit brk = 0);
    @(negedge clk);
    rx_valid = !brk; rx_break = brk; rx_byte = b;
    if (!fifo_mode) begin exp_q.delete(); exp_q.push_back(brk ? 8'h00 : b); end
    else if (exp_q.size() < 16) exp_q.push_back(brk ? 8'h00 : b);
    @(negedge clk);
    rx_valid = 0; rx_break = 0;
  endtask

  task automatic rd();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    if (v[1] || (v[0] != fifo_mode)) exp_q.delete();
    fifo_mode = v[0];
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1;
      @(negedge clk); bit_tick = 0;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11
    chk(level == 0 && !data_ready && !trigger_hit, "R11 empty", level, 0);
    chk(!break_flag && !overrun_flag && !timeout_pend, "R11 flags",
        {break_flag, overrun_flag, timeout_pend}, 0);
    chk(rd_data == 0, "R11 rd_data", rd_data, 0);

    // R10 holding register
    push(8'h11);
    chk(level == 1 && data_ready && trigger_hit && !overrun_flag, "R10 one byte", level, 1);
    push(8'h22);
    chk(overrun_flag && level == 1, "R10 overrun", overrun_flag, 1);
    rd();
    chk(!data_ready && level == 0, "R10 read clears", data_ready, 0);

    // R4 enable toggles flush
    ctl(8'h01);
    chk(!overrun_flag && level == 0, "R4 toggle flush", overrun_flag, 0);

    // R2 thresholds
    for (int i = 0; i < 5; i++) push(8'h30 + 8'(i));
    chk(level == 5 && trigger_hit, "R2 thr1", level, 5);
    ctl(8'h41);
    chk(level == 5 && trigger_hit, "R2 thr4", trigger_hit, 1);
    ctl(8'h81);
    chk(!trigger_hit, "R2 thr8 below", trigger_hit, 0);
    for (int i = 5; i < 8; i++) push(8'h30 + 8'(i));
    chk(trigger_hit && level == 8, "R2 thr8 at", level, 8);
    ctl(8'hC1);
    for (int i = 8; i < 13; i++) push(8'h30 + 8'(i));
    chk(!trigger_hit && level == 13, "R2 thr14 below", level, 13);
    push(8'h3D);
    chk(trigger_hit && level == 14, "R2 thr14 at", level, 14);

    // R3 overrun without overwrite
    push(8'h3E); push(8'h3F);
    chk(level == 16 && !overrun_flag && data_ready, "R1 full", level, 16);
    push(8'hEE);
    chk(overrun_flag && level == 16, "R3 overrun", overrun_flag, 1);
    for (int i = 0; i < 16; i++) rd();
    chk(level == 0 && !data_ready, "R1 drained", level, 0);

    // R9 empty read
    rd();
    chk(level == 0, "R9 empty level", level, 0);
    push(8'h5A);
    rd();
    chk(level == 0, "R9 pointers", level, 0);

    // R7 break
    ctl(8'h03);
    chk(!overrun_flag, "R4 flush clears overrun", overrun_flag, 1'b0);
    push(8'h00, 1);
    chk(break_flag && data_ready && level == 1, "R7 break", break_flag, 1);
    push(8'h77);
    rd();
    chk(break_flag && data_ready, "R6 break held with data", break_flag, 1);
    rd();
    chk(!break_flag && !data_ready, "R6 break cleared on empty", break_flag, 0);

    // R5/R8 timeout, 10-bit frame -> 40 ticks
    push(8'h01); push(8'h02);
    tick(39);
    chk(!timeout_pend, "R5 before 40", timeout_pend, 0);
    tick(1);
    chk(timeout_pend, "R5 at 40", timeout_pend, 1);
    rd();
    chk(!timeout_pend && level == 1, "R6 read clears tmo", timeout_pend, 0);
    tick(39);
    chk(!timeout_pend, "R5 restart after read", timeout_pend, 0);
    tick(1);
    chk(timeout_pend, "R5 refire", timeout_pend, 1);
    lc_wlen = 2'd0; lc_parity = 1; lc_stop2 = 1;
    rd();
    push(8'h03);
    tick(35);
    chk(!timeout_pend, "R8 before 36", timeout_pend, 0);
    tick(1);
    chk(timeout_pend, "R8 at 36", timeout_pend, 1);
    ctl(8'h03);
    chk(!timeout_pend && level == 0, "R4 flush clears tmo", timeout_pend, 0);
    tick(50);
    chk(!timeout_pend, "R5 empty holds", timeout_pend, 0);

    // R4 flush bit does not stick
    push(8'h04);
    ctl(8'h01);
    chk(level == 1, "R4 no flush", level, 1);
    rd();

    repeat (3) @(negedge clk);
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule